// File: doc/BRIEF.md
# Accumulator Bit Manipulation Unit

This unit sits beside a pair of 36-bit main accumulators. It carries out one bit-level operation per cycle on their contents. The operations are signed-amount barrel shifts (arithmetic or logical), exponent counting and normalisation, and bit-field extraction and insertion. It also moves data between a main accumulator and one of two 36-bit alternate accumulators that the unit holds itself. The result comes back one cycle later on a write-back port, together with the index of the main accumulator to update and a byte of status flags.

A 16-bit control word sets the shift amount or the field geometry. It is picked from one of four control registers, the immediate word, or bits 31:16 of either main accumulator. The control registers double as general-purpose storage through a separate write port and a combinational read port. A field operation that names an accumulator half, or any operation that names the reserved source, is refused. A refused operation raises an error pulse and changes nothing.

Top module: `acc_bit_unit`

## Requirements
- R1: For every cycle in which `rst_n` is low at the clock edge, the next cycle shows `wb_valid`=0, `flags`=0 and `ctl_err`=0, and both alternate accumulators are cleared to zero.
- R2: When `creg_we`=1, `creg_wdata` is stored at the edge into control register `creg_waddr`. `creg_rdata` always shows the register addressed by `creg_raddr`.
- R3: `ctl_sel` chooses the control word: codes 0 to 3 select a control register, 4 selects `imm_word`, 5 selects `acc0_in[31:16]`, 6 selects `acc1_in[31:16]`, and 7 is reserved.
- R4: Shift ops (code 1 arithmetic, code 2 logical) move the source accumulator (`src_acc`) by the signed 7-bit amount in control bits 6:0. A positive amount shifts left with zero fill. A negative amount shifts right, with sign fill (arithmetic) or zero fill (logical).
- R5: A shift magnitude of 36 or more gives all zeros, except for an arithmetic right shift, which gives 36 copies of bit 35.
- R6: Op 4 returns the exponent: the number of consecutive bits from bit 30 downward that equal bit 31. The count is 31 when bits 31:0 are all equal. Op 3 returns the source shifted left by that count.
- R7: Op 5 extracts a field. The width is in control bits 13:8 and the offset in bits 5:0. The field is returned right-justified and zero-filled. A width of 36 or more takes every bit, and an offset of 36 or more gives zero.
- R8: Op 6 writes the low `width` bits of the source into the accumulator selected by `dst_acc`, starting at the offset. Bits outside the field are kept, and bits beyond bit 35 are dropped.
- R9: A field op (5 or 6) with `ctl_sel` 5 or 6, or a control-using op (1, 2, 5 or 6) with `ctl_sel` 7, is refused. The next cycle shows `ctl_err`=1 and `wb_valid`=0, and the flags and alternate accumulators stay as they were.
- R10: `alt_sel` picks an alternate accumulator. Op 7 copies the source into it with no write-back. Op 8 writes it back to `src_acc`. Op 9 does both in the same cycle.
- R11: `flags` describes the value produced: bit 0 is negative (bit 35), bit 1 zero, bit 2 left-shift logical overflow (a non-zero bit shifted out), bit 3 bits 35:31 not all equal, bit 4 odd parity, bit 5 even parity, bit 6 all ones, bit 7 not all ones.
- R12: An accepted op with `op_valid`=1 shows its result one cycle later. `wb_idx` is `dst_acc` for ops 1 to 6 and `src_acc` for ops 8 and 9. With no op, or with codes 0, 7 or 10 to 15, `wb_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation code |
| ctl_sel | input | 3 | Control word source |
| imm_word | input | 16 | Immediate control word |
| src_acc | input | 1 | Source main accumulator index |
| dst_acc | input | 1 | Destination main accumulator index |
| alt_sel | input | 1 | Alternate accumulator index |
| acc0_in | input | 36 | Main accumulator 0 value |
| acc1_in | input | 36 | Main accumulator 1 value |
| creg_we | input | 1 | Control register write enable |
| creg_waddr | input | 2 | Control register write address |
| creg_wdata | input | 16 | Control register write data |
| creg_raddr | input | 2 | Control register read address |
| creg_rdata | output | 16 | Control register read data |
| wb_valid | output | 1 | Write-back strobe |
| wb_idx | output | 1 | Main accumulator to update |
| wb_data | output | 36 | Write-back value |
| flags | output | 8 | Status flags |
| ctl_err | output | 1 | Operation refused |

## Verification
On every cycle the assertions check the quiet state after reset and the one-cycle latency of accepted operations. They also check that idle cycles stay silent, that refused field operations raise the error with no write-back and frozen flags, and that the parity, zero and all-ones flags agree with the written value. The actual shift, saturation, exponent, field and exchange values are checked only by the bench's scenarios. The bench compares each case against results worked out by hand from the requirements, including the saturating amounts, the all-equal exponent operands, fields that run past bit 35, and round trips through the alternate accumulators.

// File: rtl/abm_pkg.sv
// Package: shared operation codes, control-source codes and flag bit
// positions for the accumulator bit manipulation unit.
// Assumes: the 4-bit op field and 3-bit source field of the top module.
package abm_pkg;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_SHA   = 4'd1,
        OP_SHL   = 4'd2,
        OP_NORM  = 4'd3,
        OP_EXP   = 4'd4,
        OP_EXT   = 4'd5,
        OP_INS   = 4'd6,
        OP_APUT  = 4'd7,
        OP_AGET  = 4'd8,
        OP_ASWAP = 4'd9
    } op_e;

    localparam int SEL_W = 3;
    localparam logic [SEL_W-1:0] SEL_IMM = 3'd4;
    localparam logic [SEL_W-1:0] SEL_A0H = 3'd5;
    localparam logic [SEL_W-1:0] SEL_A1H = 3'd6;
    localparam logic [SEL_W-1:0] SEL_RSV = 3'd7;

    localparam int FLAG_W   = 8;
    localparam int F_NEG    = 0;
    localparam int F_ZERO   = 1;
    localparam int F_LOV    = 2;
    localparam int F_MOV    = 3;
    localparam int F_ODD    = 4;
    localparam int F_EVEN   = 5;
    localparam int F_EQM1   = 6;
    localparam int F_NEM1   = 7;

endpackage

// File: rtl/abm_ctl_mux.sv
// Control register file and control word selector.
// Holds NUM_CREG general-purpose control registers with one write port
// and one combinational read port, and picks the operation control word
// from a register, the immediate word or an accumulator upper half.
// Assumes: source codes below NUM_CREG address registers (NUM_CREG = 4).
module abm_ctl_mux
    import abm_pkg::*;
#(
    parameter int DATA_W   = 36,
    parameter int CTL_W    = 16,
    parameter int NUM_CREG = 4,
    parameter int HALF_LO  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [$clog2(NUM_CREG)-1:0] wr_addr,
    input  logic [CTL_W-1:0]            wr_data,
    input  logic [$clog2(NUM_CREG)-1:0] rd_addr,
    output logic [CTL_W-1:0]            rd_data,
    input  logic [SEL_W-1:0]            sel,
    input  logic [CTL_W-1:0]            imm,
    input  logic [DATA_W-1:0]           acc0,
    input  logic [DATA_W-1:0]           acc1,
    output logic [CTL_W-1:0]            ctl_word,
    output logic                        sel_is_acc,
    output logic                        sel_rsv
);
    localparam int AW      = $clog2(NUM_CREG);
    localparam int HALF_HI = HALF_LO + CTL_W - 1;

    logic [CTL_W-1:0] creg_q [NUM_CREG];

    // One storage process per control register.
    for (genvar g = 0; g < NUM_CREG; g++) begin : g_creg
        always_ff @(posedge clk) begin
            if (!rst_n)
                creg_q[g] <= '0;
            else if (wr_en && wr_addr == AW'(g))
                creg_q[g] <= wr_data;
        end
    end

    // Data-move read port.
    assign rd_data = creg_q[rd_addr];

    // Control word source selection.
    always_comb begin
        ctl_word = '0;
        case (sel)
            SEL_IMM: ctl_word = imm;
            SEL_A0H: ctl_word = acc0[HALF_HI:HALF_LO];
            SEL_A1H: ctl_word = acc1[HALF_HI:HALF_LO];
            SEL_RSV: ctl_word = '0;
            default: ctl_word = creg_q[sel[AW-1:0]];
        endcase
    end

    // Source classification used for operation refusal.
    assign sel_is_acc = (sel == SEL_A0H) || (sel == SEL_A1H);
    assign sel_rsv    = (sel == SEL_RSV);

endmodule

// File: rtl/abm_shifter.sv
// Barrel shifter with exponent counter and normaliser.
// Shifts by a signed amount (positive = left), saturating for magnitudes
// of DATA_W or more. It reports whether a left shift dropped a set bit.
// The exponent counts the bits below EXP_REF that equal bit EXP_REF.
// Assumes: SHAMT_W bits hold magnitudes up to 2**(SHAMT_W-1).
module abm_shifter #(
    parameter int DATA_W  = 36,
    parameter int SHAMT_W = 7,
    parameter int EXP_REF = 31
) (
    input  logic [DATA_W-1:0]  data,
    input  logic [SHAMT_W-1:0] amt,
    input  logic               arith,
    output logic [DATA_W-1:0]  shifted,
    output logic               lost,
    output logic [DATA_W-1:0]  exp_val,
    output logic [DATA_W-1:0]  norm_val
);
    localparam int CW = $clog2(DATA_W + 1);
    localparam int EW = $clog2(EXP_REF + 1);
    localparam logic [SHAMT_W-1:0] LIM = SHAMT_W'(DATA_W);
    localparam logic [CW-1:0] CLIM = CW'(DATA_W);

    logic               go_left;
    logic [SHAMT_W-1:0] mag;
    logic               sat;
    logic [CW-1:0]      clamp;
    logic [2*DATA_W-1:0] wide;
    logic [EW-1:0]      cnt;
    logic               run;

    // Direction, magnitude and saturation of the requested shift.
    always_comb begin
        go_left = !amt[SHAMT_W-1];
        mag     = go_left ? amt : (~amt + SHAMT_W'(1));
        sat     = (mag >= LIM);
        clamp   = sat ? CLIM : mag[CW-1:0];
    end

    // Shift result with sign or zero fill.
    always_comb begin
        if (go_left)
            shifted = sat ? '0 : (data << mag);
        else if (arith)
            shifted = sat ? {DATA_W{data[DATA_W-1]}} : DATA_W'($signed(data) >>> mag);
        else
            shifted = sat ? '0 : (data >> mag);
    end

    // Bits pushed past the top on a left shift.
    always_comb begin
        wide = {{DATA_W{1'b0}}, data} << clamp;
        lost = go_left && (|wide[2*DATA_W-1:DATA_W]);
    end

    // Redundant sign bit count below the reference bit.
    always_comb begin
        cnt = '0;
        run = 1'b1;
        for (int i = EXP_REF - 1; i >= 0; i--) begin
            if (run && (data[i] == data[EXP_REF]))
                cnt = cnt + EW'(1);
            else
                run = 1'b0;
        end
    end

    assign exp_val  = DATA_W'(cnt);
    assign norm_val = data << cnt;

endmodule

// File: rtl/abm_field.sv
// Bit-field extractor and inserter.
// Width and offset come from the control word. Extraction right-justifies
// the field with zero fill; insertion merges the low bits of the source
// into the destination at the offset, dropping bits past the top.
// Assumes: width and offset fields are unsigned.
module abm_field #(
    parameter int DATA_W = 36,
    parameter int CTL_W  = 16,
    parameter int FW_HI  = 13,
    parameter int FW_LO  = 8,
    parameter int FO_HI  = 5,
    parameter int FO_LO  = 0
) (
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] dst,
    input  logic [CTL_W-1:0]  ctl,
    output logic [DATA_W-1:0] extracted,
    output logic [DATA_W-1:0] inserted
);
    localparam int WW = FW_HI - FW_LO + 1;
    localparam int OW = FO_HI - FO_LO + 1;
    localparam logic [WW-1:0] WLIM = WW'(DATA_W);
    localparam logic [OW-1:0] OLIM = OW'(DATA_W);

    logic [WW-1:0]     width;
    logic [OW-1:0]     offset;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] place;

    // Field geometry and masks.
    always_comb begin
        width  = ctl[FW_HI:FW_LO];
        offset = ctl[FO_HI:FO_LO];
        mask   = (width >= WLIM) ? '1 : ((DATA_W'(1) << width) - DATA_W'(1));
        place  = (offset >= OLIM) ? '0 : (mask << offset);
    end

    // Extraction and insertion results.
    always_comb begin
        extracted = (offset >= OLIM) ? '0 : ((src >> offset) & mask);
        inserted  = (dst & ~place) | (((src & mask) << offset) & place);
    end

endmodule

// File: rtl/abm_flags.sv
// Status flag generator for a produced value.
// Assumes: bits DATA_W-1 down to EXP_REF form the guard-plus-sign range.
module abm_flags
    import abm_pkg::*;
#(
    parameter int DATA_W  = 36,
    parameter int EXP_REF = 31
) (
    input  logic [DATA_W-1:0] value,
    input  logic              lov,
    output logic [FLAG_W-1:0] flags
);
    logic [DATA_W-1:EXP_REF] top;

    // Flag vector assembly.
    always_comb begin
        top            = value[DATA_W-1:EXP_REF];
        flags          = '0;
        flags[F_NEG]   = value[DATA_W-1];
        flags[F_ZERO]  = (value == '0);
        flags[F_LOV]   = lov;
        flags[F_MOV]   = !((&top) || !(|top));
        flags[F_ODD]   = ^value;
        flags[F_EVEN]  = ~^value;
        flags[F_EQM1]  = &value;
        flags[F_NEM1]  = ~&value;
    end

endmodule

// File: rtl/acc_bit_unit.sv
// Accumulator bit manipulation unit, top level.
// Reads two main accumulators and performs shift, exponent, normalise,
// field extract/insert or alternate accumulator exchange. Results,
// flags and the refusal pulse are registered: one cycle of latency.
// Assumes: the core writes wb_data into the indicated accumulator.
module acc_bit_unit
    import abm_pkg::*;
#(
    parameter int DATA_W   = 36,
    parameter int CTL_W    = 16,
    parameter int NUM_CREG = 4,
    parameter int NUM_ALT  = 2,
    parameter int SHAMT_W  = 7,
    parameter int EXP_REF  = 31,
    parameter int FW_HI    = 13,
    parameter int FW_LO    = 8,
    parameter int FO_HI    = 5,
    parameter int FO_LO    = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        op_valid,
    input  logic [3:0]                  op_code,
    input  logic [2:0]                  ctl_sel,
    input  logic [CTL_W-1:0]            imm_word,
    input  logic                        src_acc,
    input  logic                        dst_acc,
    input  logic [$clog2(NUM_ALT)-1:0]  alt_sel,
    input  logic [DATA_W-1:0]           acc0_in,
    input  logic [DATA_W-1:0]           acc1_in,
    input  logic                        creg_we,
    input  logic [$clog2(NUM_CREG)-1:0] creg_waddr,
    input  logic [CTL_W-1:0]            creg_wdata,
    input  logic [$clog2(NUM_CREG)-1:0] creg_raddr,
    output logic [CTL_W-1:0]            creg_rdata,
    output logic                        wb_valid,
    output logic                        wb_idx,
    output logic [DATA_W-1:0]           wb_data,
    output logic [7:0]                  flags,
    output logic                        ctl_err
);
    localparam int ALT_AW  = $clog2(NUM_ALT);
    localparam int HALF_LO = EXP_REF + 1 - CTL_W;

    op_e               op;
    logic [CTL_W-1:0]  ctl_word;
    logic              sel_is_acc;
    logic              sel_rsv;
    logic [DATA_W-1:0] src_val;
    logic [DATA_W-1:0] dst_val;
    logic [DATA_W-1:0] sh_val;
    logic              sh_lost;
    logic [DATA_W-1:0] exp_val;
    logic [DATA_W-1:0] norm_val;
    logic [DATA_W-1:0] ext_val;
    logic [DATA_W-1:0] ins_val;
    logic [DATA_W-1:0] alt_q [NUM_ALT];
    logic [DATA_W-1:0] alt_rd;
    logic              uses_ctl;
    logic              is_field;
    logic              refuse;
    logic              accept;
    logic [DATA_W-1:0] res_c;
    logic              lov_c;
    logic              has_wb;
    logic              has_flags;
    logic              wb_to_src;
    logic              alt_wr;
    logic [FLAG_W-1:0] flags_c;

    assign op      = op_e'(op_code);
    assign src_val = src_acc ? acc1_in : acc0_in;
    assign dst_val = dst_acc ? acc1_in : acc0_in;
    assign alt_rd  = alt_q[alt_sel];

    abm_ctl_mux #(
        .DATA_W   (DATA_W),
        .CTL_W    (CTL_W),
        .NUM_CREG (NUM_CREG),
        .HALF_LO  (HALF_LO)
    ) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (creg_we),
        .wr_addr    (creg_waddr),
        .wr_data    (creg_wdata),
        .rd_addr    (creg_raddr),
        .rd_data    (creg_rdata),
        .sel        (ctl_sel),
        .imm        (imm_word),
        .acc0       (acc0_in),
        .acc1       (acc1_in),
        .ctl_word   (ctl_word),
        .sel_is_acc (sel_is_acc),
        .sel_rsv    (sel_rsv)
    );

    abm_shifter #(
        .DATA_W  (DATA_W),
        .SHAMT_W (SHAMT_W),
        .EXP_REF (EXP_REF)
    ) u_sh (
        .data     (src_val),
        .amt      (ctl_word[SHAMT_W-1:0]),
        .arith    (op == OP_SHA),
        .shifted  (sh_val),
        .lost     (sh_lost),
        .exp_val  (exp_val),
        .norm_val (norm_val)
    );

    abm_field #(
        .DATA_W (DATA_W),
        .CTL_W  (CTL_W),
        .FW_HI  (FW_HI),
        .FW_LO  (FW_LO),
        .FO_HI  (FO_HI),
        .FO_LO  (FO_LO)
    ) u_fld (
        .src       (src_val),
        .dst       (dst_val),
        .ctl       (ctl_word),
        .extracted (ext_val),
        .inserted  (ins_val)
    );

    // Refusal of illegal control sources.
    always_comb begin
        is_field = (op == OP_EXT) || (op == OP_INS);
        uses_ctl = is_field || (op == OP_SHA) || (op == OP_SHL);
        refuse   = op_valid && uses_ctl && (sel_rsv || (is_field && sel_is_acc));
        accept   = op_valid && !refuse;
    end

    // Operation result selection and side-effect decode.
    always_comb begin
        res_c     = '0;
        lov_c     = 1'b0;
        has_wb    = 1'b0;
        has_flags = 1'b1;
        wb_to_src = 1'b0;
        alt_wr    = 1'b0;
        case (op)
            OP_SHA, OP_SHL: begin
                res_c  = sh_val;
                lov_c  = sh_lost;
                has_wb = 1'b1;
            end
            OP_NORM: begin
                res_c  = norm_val;
                has_wb = 1'b1;
            end
            OP_EXP: begin
                res_c  = exp_val;
                has_wb = 1'b1;
            end
            OP_EXT: begin
                res_c  = ext_val;
                has_wb = 1'b1;
            end
            OP_INS: begin
                res_c  = ins_val;
                has_wb = 1'b1;
            end
            OP_APUT: begin
                res_c  = src_val;
                alt_wr = 1'b1;
            end
            OP_AGET: begin
                res_c     = alt_rd;
                has_wb    = 1'b1;
                wb_to_src = 1'b1;
            end
            OP_ASWAP: begin
                res_c     = alt_rd;
                has_wb    = 1'b1;
                wb_to_src = 1'b1;
                alt_wr    = 1'b1;
            end
            default: has_flags = 1'b0;
        endcase
    end

    abm_flags #(
        .DATA_W  (DATA_W),
        .EXP_REF (EXP_REF)
    ) u_flg (
        .value (res_c),
        .lov   (lov_c),
        .flags (flags_c)
    );

    // One storage process per alternate accumulator.
    for (genvar g = 0; g < NUM_ALT; g++) begin : g_alt
        always_ff @(posedge clk) begin
            if (!rst_n)
                alt_q[g] <= '0;
            else if (accept && alt_wr && alt_sel == ALT_AW'(g))
                alt_q[g] <= src_val;
        end
    end

    // Registered write-back, flags and refusal pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_idx   <= 1'b0;
            wb_data  <= '0;
            flags    <= '0;
            ctl_err  <= 1'b0;
        end else begin
            wb_valid <= accept && has_wb;
            ctl_err  <= refuse;
            if (accept && has_wb) begin
                wb_idx  <= wb_to_src ? src_acc : dst_acc;
                wb_data <= res_c;
            end
            if (accept && has_flags)
                flags <= flags_c;
        end
    end

endmodule

// File: rtl/abm_checker.sv
// Property checker for the accumulator bit manipulation unit, bound to
// every instance of the top module.
// Assumes: synchronous active-low reset and the flag layout in abm_pkg.
module abm_checker
    import abm_pkg::*;
#(
    parameter int DATA_W  = 36,
    parameter int EXP_REF = 31
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [3:0]        op_code,
    input logic [2:0]        ctl_sel,
    input logic              wb_valid,
    input logic [DATA_W-1:0] wb_data,
    input logic [7:0]        flags,
    input logic              ctl_err
);
    logic field_op;
    logic acc_src;
    logic ok_op;

    assign field_op = (op_code == OP_EXT) || (op_code == OP_INS);
    assign acc_src  = (ctl_sel == SEL_A0H) || (ctl_sel == SEL_A1H);
    assign ok_op    = op_valid && (ctl_sel != SEL_RSV) && !acc_src &&
                      (op_code >= 4'd1) && (op_code <= 4'd6);

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!wb_valid && flags == '0 && !ctl_err));

    a_r9_field_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && field_op && acc_src) |=> (ctl_err && !wb_valid));

    a_r9_flags_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_err |-> (flags == $past(flags)));

    a_r12_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ok_op |=> (wb_valid && !ctl_err));

    a_r12_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!wb_valid && !ctl_err));

    a_r6_exp_range: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_EXP) |=> (wb_valid && wb_data <= DATA_W'(EXP_REF)));

    a_r11_parity: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (flags[F_ODD] == ^wb_data && flags[F_EVEN] != flags[F_ODD]));

    a_r11_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (flags[F_ZERO] == (wb_data == '0)));

    a_r11_minus_one: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (flags[F_EQM1] == (&wb_data) && flags[F_NEM1] != flags[F_EQM1]));

endmodule

bind acc_bit_unit abm_checker #(
    .DATA_W  (DATA_W),
    .EXP_REF (EXP_REF)
) u_abm_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .ctl_sel  (ctl_sel),
    .wb_valid (wb_valid),
    .wb_data  (wb_data),
    .flags    (flags),
    .ctl_err  (ctl_err)
);

// File: tb/acc_bit_unit_test.sv
// Testbench for acc_bit_unit: a vector table walked by one loop, then
// directed cases for reset, control registers, refusal and exchanges.
module acc_bit_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 22;

    typedef struct packed {
        logic [3:0]  op;
        logic [2:0]  sel;
        logic [15:0] imm;
        logic [35:0] a0;
        logic [35:0] a1;
        logic        src;
        logic        dst;
        logic [35:0] exp;
        logic        lov;
        logic [7:0]  req;
    } vec_t;

    // Table columns: op, sel, imm, a0, a1, src, dst, expected, lov, requirement
    localparam vec_t VECS [NVEC] = '{
        '{4'd1, 3'd4, 16'h0004, 36'h0_0000_00F3, 36'h0, 1'b0, 1'b1, 36'h0_0000_0F30, 1'b0, 8'd4},  // R4 left
        '{4'd1, 3'd4, 16'h007C, 36'h8_0000_0000, 36'h0, 1'b0, 1'b1, 36'hF_8000_0000, 1'b0, 8'd4},  // R4 arith right
        '{4'd2, 3'd4, 16'h007C, 36'h8_0000_0000, 36'h0, 1'b0, 1'b1, 36'h0_8000_0000, 1'b0, 8'd4},  // R4 logic right
        '{4'd1, 3'd4, 16'h0001, 36'h8_0000_0001, 36'h0, 1'b0, 1'b0, 36'h0_0000_0002, 1'b1, 8'd11}, // R11 lov
        '{4'd1, 3'd4, 16'h0040, 36'h8_0000_1234, 36'h0, 1'b0, 1'b0, 36'hF_FFFF_FFFF, 1'b0, 8'd5},  // R5 -64 arith
        '{4'd2, 3'd4, 16'h0040, 36'h8_0000_1234, 36'h0, 1'b0, 1'b0, 36'h0,           1'b0, 8'd5},  // R5 -64 logic
        '{4'd1, 3'd4, 16'h003F, 36'h0_0000_0001, 36'h0, 1'b0, 1'b0, 36'h0,           1'b1, 8'd5},  // R5 +63
        '{4'd1, 3'd4, 16'h005D, 36'h8_0000_0000, 36'h0, 1'b0, 1'b0, 36'hF_FFFF_FFFF, 1'b0, 8'd5},  // R5 -35 arith
        '{4'd2, 3'd4, 16'h005D, 36'h8_0000_0000, 36'h0, 1'b0, 1'b0, 36'h0_0000_0001, 1'b0, 8'd5},  // R5 -35 logic
        '{4'd1, 3'd5, 16'h0000, 36'h0_0003_0001, 36'h0, 1'b0, 1'b1, 36'h0_0018_0008, 1'b0, 8'd3},  // R3 acc0 half
        '{4'd1, 3'd6, 16'h0000, 36'h0_0000_0010, 36'h0_FFFF_0000, 1'b0, 1'b0, 36'h0_0000_0008, 1'b0, 8'd3}, // R3 acc1 half
        '{4'd4, 3'd4, 16'h0000, 36'h0, 36'h0_0000_1000, 1'b1, 1'b0, 36'h0_0000_0012, 1'b0, 8'd6},  // R6 exp
        '{4'd3, 3'd4, 16'h0000, 36'h0, 36'h0_0000_1000, 1'b1, 1'b1, 36'h0_4000_0000, 1'b0, 8'd6},  // R6 norm
        '{4'd4, 3'd4, 16'h0000, 36'h0, 36'h0,           1'b0, 1'b0, 36'h0_0000_001F, 1'b0, 8'd6},  // R6 zero
        '{4'd3, 3'd4, 16'h0000, 36'hF_FFFF_FFFF, 36'h0, 1'b0, 1'b0, 36'hF_8000_0000, 1'b0, 8'd6},  // R6 ones
        '{4'd4, 3'd4, 16'h0000, 36'hF_FFFF_F000, 36'h0, 1'b0, 1'b0, 36'h0_0000_0013, 1'b0, 8'd6},  // R6 negative
        '{4'd5, 3'd4, 16'h0804, 36'h0_0000_0AB0, 36'h0, 1'b0, 1'b1, 36'h0_0000_00AB, 1'b0, 8'd7},  // R7
        '{4'd5, 3'd4, 16'h0420, 36'hA_0000_0000, 36'h0, 1'b0, 1'b1, 36'h0_0000_000A, 1'b0, 8'd7},  // R7 top
        '{4'd5, 3'd4, 16'h0428, 36'hA_0000_0000, 36'h0, 1'b0, 1'b1, 36'h0,           1'b0, 8'd7},  // R7 offset 40
        '{4'd5, 3'd4, 16'h2800, 36'hF_0000_0001, 36'h0, 1'b0, 1'b1, 36'hF_0000_0001, 1'b0, 8'd7},  // R7 width 40
        '{4'd6, 3'd4, 16'h0808, 36'h0_0000_00CD, 36'h0_1234_5678, 1'b0, 1'b1, 36'h0_1234_CD78, 1'b0, 8'd8}, // R8
        '{4'd6, 3'd4, 16'h0422, 36'h0_0000_000F, 36'h0, 1'b0, 1'b1, 36'hC_0000_0000, 1'b0, 8'd8}   // R8 clip
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [2:0]  ctl_sel = '0;
    logic [15:0] imm_word = '0;
    logic        src_acc = 1'b0;
    logic        dst_acc = 1'b0;
    logic        alt_sel = 1'b0;
    logic [35:0] acc0_in = '0;
    logic [35:0] acc1_in = '0;
    logic        creg_we = 1'b0;
    logic [1:0]  creg_waddr = '0;
    logic [15:0] creg_wdata = '0;
    logic [1:0]  creg_raddr = '0;
    logic [15:0] creg_rdata;
    logic        wb_valid;
    logic        wb_idx;
    logic [35:0] wb_data;
    logic [7:0]  flags;
    logic        ctl_err;

    int tests = 0;
    int fails = 0;
    logic done = 1'b0;
    logic [7:0] saved_flags;

    acc_bit_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .ctl_sel(ctl_sel), .imm_word(imm_word), .src_acc(src_acc),
        .dst_acc(dst_acc), .alt_sel(alt_sel), .acc0_in(acc0_in),
        .acc1_in(acc1_in), .creg_we(creg_we), .creg_waddr(creg_waddr),
        .creg_wdata(creg_wdata), .creg_raddr(creg_raddr),
        .creg_rdata(creg_rdata), .wb_valid(wb_valid), .wb_idx(wb_idx),
        .wb_data(wb_data), .flags(flags), .ctl_err(ctl_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected flags from a value, per the R11 bit layout.
    function automatic logic [7:0] want_flags(input logic [35:0] v, input logic lov);
        logic [7:0] f;
        f[0] = v[35];
        f[1] = (v == 36'h0);
        f[2] = lov;
        f[3] = !((&v[35:31]) || !(|v[35:31]));
        f[4] = ^v;
        f[5] = ~^v;
        f[6] = &v;
        f[7] = ~&v;
        return f;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Present one operation for a cycle; outputs are read 1 time unit later.
    task automatic do_op(input logic [3:0] op, input logic [2:0] sel,
                         input logic [15:0] imm, input logic [35:0] a0,
                         input logic [35:0] a1, input logic s, input logic d,
                         input logic alt);
        op_valid = 1'b1; op_code = op; ctl_sel = sel; imm_word = imm;
        acc0_in = a0; acc1_in = a1; src_acc = s; dst_acc = d; alt_sel = alt;
        @(posedge clk);
        #1;
        op_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1", "wb_valid", 64'(wb_valid), 64'd0);
        check("R1", "flags", 64'(flags), 64'd0);
        check("R1", "ctl_err", 64'(ctl_err), 64'd0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R1: alternate accumulator cleared
        do_op(4'd8, 3'd4, 16'h0, 36'h0, 36'h0, 1'b0, 1'b0, 1'b1);
        check("R1", "alt1 after reset", 64'(wb_data), 64'd0);
        check("R12", "alt get idx", 64'(wb_idx), 64'd0);

        // Main vector table: R3 R4 R5 R6 R7 R8 R11 R12
        for (int k = 0; k < NVEC; k++) begin
            do_op(VECS[k].op, VECS[k].sel, VECS[k].imm, VECS[k].a0,
                  VECS[k].a1, VECS[k].src, VECS[k].dst, 1'b0);
            check($sformatf("R%0d vec%0d", VECS[k].req, k), "data",
                  64'(wb_data), 64'(VECS[k].exp));
            check($sformatf("R12 vec%0d", k), "valid/idx",
                  64'({wb_valid, wb_idx}), 64'({1'b1, VECS[k].dst}));
            check($sformatf("R11 vec%0d", k), "flags",
                  64'(flags), 64'(want_flags(VECS[k].exp, VECS[k].lov)));
        end

        // R2: control register write and read-back
        creg_we = 1'b1; creg_waddr = 2'd1; creg_wdata = 16'hBEEF;
        @(posedge clk); #1;
        creg_waddr = 2'd2; creg_wdata = 16'h0002;
        @(posedge clk); #1;
        creg_we = 1'b0;
        creg_raddr = 2'd1; #1;
        check("R2", "creg1", 64'(creg_rdata), 64'hBEEF);
        creg_raddr = 2'd2; #1;
        check("R2", "creg2", 64'(creg_rdata), 64'h0002);
        creg_raddr = 2'd0; #1;
        check("R2", "creg0 untouched", 64'(creg_rdata), 64'h0);

        // R3: shift amount taken from control register 2
        do_op(4'd1, 3'd2, 16'h0, 36'h0_0000_0005, 36'h0, 1'b0, 1'b0, 1'b0);
        check("R3", "creg source shift", 64'(wb_data), 64'h14);

        // R9: refused field op with accumulator-half source
        saved_flags = flags;
        do_op(4'd5, 3'd5, 16'h0, 36'h0_0804_0AB0, 36'h0, 1'b0, 1'b0, 1'b0);
        check("R9", "ctl_err ext", 64'(ctl_err), 64'd1);
        check("R9", "no wb ext", 64'(wb_valid), 64'd0);
        check("R9", "flags held", 64'(flags), 64'(saved_flags));
        do_op(4'd6, 3'd6, 16'h0, 36'h0, 36'h0_0808_0000, 1'b0, 1'b1, 1'b0);
        check("R9", "ctl_err ins", 64'(ctl_err), 64'd1);
        check("R9", "flags held ins", 64'(flags), 64'(saved_flags));
        do_op(4'd1, 3'd7, 16'h0, 36'h1, 36'h0, 1'b0, 1'b0, 1'b0);
        check("R9", "reserved source", 64'({ctl_err, wb_valid}), 64'b10);
        // R9: refused op with alt select must not disturb an alternate
        do_op(4'd8, 3'd4, 16'h0, 36'h0, 36'h0, 1'b0, 1'b0, 1'b0);
        check("R9", "alt0 untouched", 64'(wb_data), 64'd0);

        // R10: copy to alternate, read back, swap
        do_op(4'd7, 3'd4, 16'h0, 36'h9_1234_5678, 36'h0, 1'b0, 1'b0, 1'b0);
        check("R10", "put no wb", 64'({wb_valid, ctl_err}), 64'b00);
        check("R11", "put flags", 64'(flags), 64'(want_flags(36'h9_1234_5678, 1'b0)));
        do_op(4'd8, 3'd4, 16'h0, 36'h0, 36'h0, 1'b1, 1'b0, 1'b0);
        check("R10", "get data", 64'(wb_data), 64'h9_1234_5678);
        check("R10", "get idx", 64'({wb_valid, wb_idx}), 64'b11);
        do_op(4'd9, 3'd4, 16'h0, 36'h0, 36'h0_0000_0042, 1'b1, 1'b0, 1'b0);
        check("R10", "swap out", 64'(wb_data), 64'h9_1234_5678);
        do_op(4'd8, 3'd4, 16'h0, 36'h0, 36'h0, 1'b0, 1'b1, 1'b0);
        check("R10", "swap in", 64'(wb_data), 64'h42);
        do_op(4'd8, 3'd4, 16'h0, 36'h0, 36'h0, 1'b0, 1'b0, 1'b1);
        check("R10", "alt1 untouched", 64'(wb_data), 64'h0);

        // R12: NOP and unused code produce no write-back
        do_op(4'd0, 3'd4, 16'h0, 36'h5, 36'h0, 1'b0, 1'b0, 1'b0);
        check("R12", "nop", 64'(wb_valid), 64'd0);
        do_op(4'd12, 3'd4, 16'h0, 36'h5, 36'h0, 1'b0, 1'b0, 1'b0);
        check("R12", "unused code", 64'(wb_valid), 64'd0);

        // R1: reset clears state again mid-run
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R1", "mid reset flags", 64'({flags, wb_valid, ctl_err}), 64'd0);
        rst_n = 1'b1;
        do_op(4'd8, 3'd4, 16'h0, 36'h0, 36'h0, 1'b0, 1'b0, 1'b0);
        check("R1", "alt0 cleared", 64'(wb_data), 64'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule